// File: doc/BRIEF.md
# DSI Lane Rate and Timing Configurator

This block turns a display mode into the per-lane settings that a serial display link needs. From the pixel clock in kHz, a pixel format code and the number of data lanes, it works out the raw per-lane bit rate. It adds a fixed 20% headroom so that burst transfers finish ahead of the pixel stream. It then clamps the result to the lane rate window of the attached PHY. That window is wider on one hardware revision, which is recognised from a version word.

A second set of values is derived from the rate the clock generator actually delivers, after its divider settings have been chosen elsewhere: the high-speed bit period written as four times the unit interval, the lane rate rounded down to whole Mbps, and the color multiplexing code for the chosen format. Every division runs on one shared bit-serial divider. A request is a single `start` pulse, and the answer is published together with a one-cycle `done` pulse.

Top module: `dsi_lane_rate_cfg`

## Requirements
- R1: Target rate = floor(floor(pix_khz × bpp / lanes) × 12 / 10), computed from the values sampled with `start_i`.
- R2: The default lane window is 31,250 to 500,000 kbps.
- R3: When bits 31:8 of the version word equal 0x313331, both window limits double to 62,500 and 1,000,000 kbps.
- R4: The target is first limited to the maximum and then raised to the minimum. `warn_max_o` is set when the maximum clamp took effect and `warn_min_o` when the minimum clamp took effect.
- R5: `uix4_o` = floor(4,000,000 / pll_khz) kept to its low 6 bits. A PLL rate of 0 gives 63.
- R6: Color code (format code → code): 0 (RGB888) → 5, 1 (loose RGB666) → 4, 2 (packed RGB666) → 3, 3 (RGB565) → 0. Codes 4–7 fall back to 5.
- R7: Bits per pixel: 24 for format codes 0, 1 and 4–7, 18 for code 2, and 16 for code 3.
- R8: `lane_mbps_o` = floor(pll_khz / 1000).
- R9: `done_o` is high for exactly one cycle per accepted request. A `start_i` pulse while a request is in flight is ignored and produces no extra `done_o`.
- R10: A lane count of 0 is treated as one lane.
- R11: After reset all outputs are 0. Outputs change only in the cycle `done_o` is high and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse; inputs are sampled with it |
| pix_khz_i | input | PIX_W (20) | Pixel clock in kHz |
| fmt_i | input | 3 | Pixel format code |
| lanes_i | input | LANE_W (3) | Number of data lanes |
| version_i | input | 32 | Hardware version word |
| pll_khz_i | input | DIV_W (32) | Final PLL output rate in kHz |
| done_o | output | 1 | Result valid pulse |
| target_kbps_o | output | DIV_W (32) | Clamped target lane rate in kbps |
| uix4_o | output | UI_W (6) | Unit interval ×4 field |
| color_o | output | 3 | Color multiplexing code |
| lane_mbps_o | output | DIV_W (32) | Lane rate in whole Mbps |
| warn_max_o | output | 1 | Maximum clamp applied |
| warn_min_o | output | 1 | Minimum clamp applied |

## Verification
On every cycle the assertions check several properties: the published target lies inside the window currently selected, each warning flag comes with a target equal to the matching limit, the color code is one of the four legal values, `done_o` never lasts two cycles, and the outputs stay frozen between results. The arithmetic itself can only be shown by the bench scenarios. These cover the rounding of each division, which limit applies for a given version word, the fallback for unknown formats, a lane count of zero, a PLL rate of zero, and a second request sent while one is still running.

// File: rtl/dsi_lrc_pkg.sv
`timescale 1ns/1ps
package dsi_lrc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BASE,
      ST_MARG,
      ST_UI,
      ST_MBPS
   } lrc_state_t;

   localparam logic [2:0] FMT_RGB888  = 3'd0;
   localparam logic [2:0] FMT_RGB666L = 3'd1;
   localparam logic [2:0] FMT_RGB666P = 3'd2;
   localparam logic [2:0] FMT_RGB565  = 3'd3;

   localparam logic [2:0] COL_565  = 3'd0;
   localparam logic [2:0] COL_666P = 3'd3;
   localparam logic [2:0] COL_666L = 3'd4;
   localparam logic [2:0] COL_888  = 3'd5;

endpackage

// File: rtl/dsi_lrc_div.sv
`timescale 1ns/1ps
// Restoring bit-serial divider: one quotient bit per cycle.
// A zero divisor yields an all-ones quotient.
module dsi_lrc_div #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         done_o,
   output logic [W-1:0] quo_o
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q, quo_q, den_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q, done_q;
   logic [W:0]    trial;
   logic          fits;

   assign trial = {rem_q, quo_q[W-1]};
   assign fits  = trial >= {1'b0, den_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            rem_q  <= '0;
            quo_q  <= num_i;
            den_q  <= den_i;
            cnt_q  <= CW'(W);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            rem_q <= fits ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o = done_q;
   assign quo_o  = quo_q;
endmodule

// File: rtl/dsi_lrc_fmt.sv
`timescale 1ns/1ps
// Pixel format decode: wire bits per pixel and color multiplexing code.
module dsi_lrc_fmt
   import dsi_lrc_pkg::*;
(
   input  logic [2:0] fmt_i,
   output logic [4:0] bpp_o,
   output logic [2:0] color_o
);
   always_comb begin
      case (fmt_i)
         FMT_RGB666L: begin bpp_o = 5'd24; color_o = COL_666L; end
         FMT_RGB666P: begin bpp_o = 5'd18; color_o = COL_666P; end
         FMT_RGB565:  begin bpp_o = 5'd16; color_o = COL_565;  end
         default:     begin bpp_o = 5'd24; color_o = COL_888;  end
      endcase
   end
endmodule

// File: rtl/dsi_lrc_limits.sv
`timescale 1ns/1ps
// Lane rate window, widened on the matching hardware revision.
module dsi_lrc_limits #(
   parameter int          DIV_W    = 32,
   parameter int unsigned MIN_KBPS = 31250,
   parameter int unsigned MAX_KBPS = 500000,
   parameter logic [23:0] FAST_ID  = 24'h313331
) (
   input  logic [31:0]      version_i,
   output logic             fast_o,
   output logic [DIV_W-1:0] min_o,
   output logic [DIV_W-1:0] max_o
);
   assign fast_o = (version_i >> 8) == {8'd0, FAST_ID};
   assign min_o  = fast_o ? DIV_W'(MIN_KBPS * 2) : DIV_W'(MIN_KBPS);
   assign max_o  = fast_o ? DIV_W'(MAX_KBPS * 2) : DIV_W'(MAX_KBPS);
endmodule

// File: rtl/dsi_lane_rate_cfg.sv
`timescale 1ns/1ps
module dsi_lane_rate_cfg
   import dsi_lrc_pkg::*;
#(
   parameter int          PIX_W    = 20,
   parameter int          LANE_W   = 3,
   parameter int          DIV_W    = 32,
   parameter int          UI_W     = 6,
   parameter int unsigned MIN_KBPS = 31250,
   parameter int unsigned MAX_KBPS = 500000,
   parameter logic [23:0] FAST_ID  = 24'h313331
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PIX_W-1:0]  pix_khz_i,
   input  logic [2:0]        fmt_i,
   input  logic [LANE_W-1:0] lanes_i,
   input  logic [31:0]       version_i,
   input  logic [DIV_W-1:0]  pll_khz_i,
   output logic              done_o,
   output logic [DIV_W-1:0]  target_kbps_o,
   output logic [UI_W-1:0]   uix4_o,
   output logic [2:0]        color_o,
   output logic [DIV_W-1:0]  lane_mbps_o,
   output logic              warn_max_o,
   output logic              warn_min_o
);
   localparam int unsigned UI_NUM    = 4000000;
   localparam int unsigned MARG_MUL  = 12;
   localparam int unsigned MARG_DIV  = 10;
   localparam int unsigned KHZ_PER_M = 1000;

   if (DIV_W < PIX_W + 9) begin : g_bad_div_w
      $error("DIV_W too narrow for pixel clock times bpp times margin");
   end
   if (DIV_W < 23) begin : g_bad_ui_num
      $error("DIV_W cannot hold the unit interval numerator");
   end
   if (UI_W < 1 || UI_W > DIV_W) begin : g_bad_ui_w
      $error("UI_W out of range");
   end

   lrc_state_t       state_q;
   logic [31:0]      version_q;
   logic [DIV_W-1:0] pll_q, tgt_q;
   logic [2:0]       color_q;
   logic [UI_W-1:0]  ui_q;
   logic             wmax_q, wmin_q;

   logic             div_start, div_done;
   logic [DIV_W-1:0] div_num, div_den, div_quo;
   logic [4:0]       bpp_w;
   logic [2:0]       color_w;
   logic             fast_q;
   logic [DIV_W-1:0] lim_min, lim_max;
   logic [DIV_W-1:0] clamp_val;
   logic             hit_max, hit_min;

   dsi_lrc_fmt u_fmt (
      .fmt_i   (fmt_i),
      .bpp_o   (bpp_w),
      .color_o (color_w)
   );

   dsi_lrc_limits #(
      .DIV_W    (DIV_W),
      .MIN_KBPS (MIN_KBPS),
      .MAX_KBPS (MAX_KBPS),
      .FAST_ID  (FAST_ID)
   ) u_lim (
      .version_i (version_q),
      .fast_o    (fast_q),
      .min_o     (lim_min),
      .max_o     (lim_max)
   );

   dsi_lrc_div #(.W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_start),
      .num_i   (div_num),
      .den_i   (div_den),
      .done_o  (div_done),
      .quo_o   (div_quo)
   );

   // Ceiling applied first, then the floor.
   always_comb begin
      hit_max   = div_quo > lim_max;
      clamp_val = hit_max ? lim_max : div_quo;
      hit_min   = clamp_val < lim_min;
      if (hit_min) clamp_val = lim_min;
   end

   always_comb begin
      div_start = 1'b0;
      div_num   = '0;
      div_den   = '0;
      case (state_q)
         ST_IDLE: if (start_i) begin
            div_start = 1'b1;
            div_num   = DIV_W'(pix_khz_i) * DIV_W'(bpp_w);
            div_den   = (lanes_i == '0) ? DIV_W'(1) : DIV_W'(lanes_i);
         end
         ST_BASE: if (div_done) begin
            div_start = 1'b1;
            div_num   = div_quo * DIV_W'(MARG_MUL);
            div_den   = DIV_W'(MARG_DIV);
         end
         ST_MARG: if (div_done) begin
            div_start = 1'b1;
            div_num   = DIV_W'(UI_NUM);
            div_den   = pll_q;
         end
         ST_UI: if (div_done) begin
            div_start = 1'b1;
            div_num   = pll_q;
            div_den   = DIV_W'(KHZ_PER_M);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         version_q     <= '0;
         pll_q         <= '0;
         tgt_q         <= '0;
         color_q       <= '0;
         ui_q          <= '0;
         wmax_q        <= 1'b0;
         wmin_q        <= 1'b0;
         done_o        <= 1'b0;
         target_kbps_o <= '0;
         uix4_o        <= '0;
         color_o       <= '0;
         lane_mbps_o   <= '0;
         warn_max_o    <= 1'b0;
         warn_min_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) begin
               version_q <= version_i;
               pll_q     <= pll_khz_i;
               color_q   <= color_w;
               state_q   <= ST_BASE;
            end
            ST_BASE: if (div_done) state_q <= ST_MARG;
            ST_MARG: if (div_done) begin
               tgt_q   <= clamp_val;
               wmax_q  <= hit_max;
               wmin_q  <= hit_min;
               state_q <= ST_UI;
            end
            ST_UI: if (div_done) begin
               ui_q    <= div_quo[UI_W-1:0];
               state_q <= ST_MBPS;
            end
            ST_MBPS: if (div_done) begin
               target_kbps_o <= tgt_q;
               uix4_o        <= ui_q;
               color_o       <= color_q;
               lane_mbps_o   <= div_quo;
               warn_max_o    <= wmax_q;
               warn_min_o    <= wmin_q;
               done_o        <= 1'b1;
               state_q       <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dsi_lrc_chk.sv
`timescale 1ns/1ps
module dsi_lrc_chk #(
   parameter int DIV_W = 32,
   parameter int UI_W  = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done_o,
   input logic [DIV_W-1:0] target_kbps_o,
   input logic [UI_W-1:0]  uix4_o,
   input logic [2:0]       color_o,
   input logic [DIV_W-1:0] lane_mbps_o,
   input logic             warn_max_o,
   input logic             warn_min_o,
   input logic [DIV_W-1:0] lim_min,
   input logic [DIV_W-1:0] lim_max
);
   AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (target_kbps_o >= lim_min && target_kbps_o <= lim_max)); // R2

   AST_WARN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && warn_max_o && !warn_min_o) |-> target_kbps_o == lim_max); // R4

   AST_WARN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && warn_min_o) |-> target_kbps_o == lim_min); // R4

   AST_COLOR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (color_o == 3'd0 || color_o == 3'd3 ||
                  color_o == 3'd4 || color_o == 3'd5)); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(target_kbps_o) && $stable(uix4_o) && $stable(color_o) &&
                   $stable(lane_mbps_o) && $stable(warn_max_o) && $stable(warn_min_o))); // R11
endmodule

bind dsi_lane_rate_cfg dsi_lrc_chk #(.DIV_W(DIV_W), .UI_W(UI_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .done_o        (done_o),
   .target_kbps_o (target_kbps_o),
   .uix4_o        (uix4_o),
   .color_o       (color_o),
   .lane_mbps_o   (lane_mbps_o),
   .warn_max_o    (warn_max_o),
   .warn_min_o    (warn_min_o),
   .lim_min       (lim_min),
   .lim_max       (lim_max)
);

// File: tb/sim_dsi_lane_rate_cfg.sv
`timescale 1ns/1ps
module sim_dsi_lane_rate_cfg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [19:0] pix_khz_i = '0;
   logic [2:0]  fmt_i = '0;
   logic [2:0]  lanes_i = '0;
   logic [31:0] version_i = '0;
   logic [31:0] pll_khz_i = '0;
   logic        done_o;
   logic [31:0] target_kbps_o;
   logic [5:0]  uix4_o;
   logic [2:0]  color_o;
   logic [31:0] lane_mbps_o;
   logic        warn_max_o, warn_min_o;

   int nchk = 0;
   int nfail = 0;

   // Held reference values (what the outputs must show between results)
   longint h_tgt = 0, h_ui = 0, h_col = 0, h_mbps = 0, h_wx = 0, h_wn = 0;

   always #2.5 clk = ~clk;

   dsi_lane_rate_cfg u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .pix_khz_i(pix_khz_i),
      .fmt_i(fmt_i), .lanes_i(lanes_i), .version_i(version_i), .pll_khz_i(pll_khz_i),
      .done_o(done_o), .target_kbps_o(target_kbps_o), .uix4_o(uix4_o),
      .color_o(color_o), .lane_mbps_o(lane_mbps_o),
      .warn_max_o(warn_max_o), .warn_min_o(warn_min_o)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic compare_held(input string ttag);
      check({ttag, " target"}, target_kbps_o, h_tgt);
      check("R5 uix4", uix4_o, h_ui);
      check("R6 color", color_o, h_col);
      check("R8 lane_mbps", lane_mbps_o, h_mbps);
      check("R4 warn_max", warn_max_o, h_wx);
      check("R4 warn_min", warn_min_o, h_wn);
   endtask

   task automatic run(input string ttag, input longint pix, input int fmt, input int lanes,
                      input longint ver, input longint pll, input bit poke);
      longint bpp, col, l, t, mn, mx, ui;
      bit fast, wx, wn, got;
      bpp = (fmt == 2) ? 18 : (fmt == 3) ? 16 : 24;            // R7
      col = (fmt == 0) ? 5 : (fmt == 1) ? 4 : (fmt == 2) ? 3 : (fmt == 3) ? 0 : 5; // R6
      l   = (lanes == 0) ? 1 : lanes;                          // R10
      t   = ((pix * bpp) / l) * 12 / 10;                       // R1
      fast = ((ver >> 8) & 64'hFFFFFF) == 64'h313331;          // R3
      mn  = fast ? 62500 : 31250;                              // R2
      mx  = fast ? 1000000 : 500000;
      wx  = t > mx; if (wx) t = mx;                            // R4
      wn  = t < mn; if (wn) t = mn;
      ui  = (pll == 0) ? 63 : (4000000 / pll) % 64;            // R5
      @(negedge clk);
      pix_khz_i = 20'(pix); fmt_i = 3'(fmt); lanes_i = 3'(lanes);
      version_i = 32'(ver); pll_khz_i = 32'(pll); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      got = 1'b0;
      for (int c = 0; c < 400 && !got; c++) begin
         if (poke && c == 20) begin
            pix_khz_i = 20'd1; fmt_i = 3'd3; pll_khz_i = 32'd7; start_i = 1'b1;
         end else start_i = 1'b0;
         @(negedge clk);
         if (done_o) begin
            h_tgt = t; h_ui = ui; h_col = col; h_mbps = pll / 1000;
            h_wx = wx; h_wn = wn;
            compare_held(ttag);
            got = 1'b1;
         end else begin
            compare_held("R11 hold");
         end
      end
      start_i = 1'b0;
      check("R9 done seen", got, 1);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R9 no extra done", done_o, 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 reset done", done_o, 0);
      compare_held("R11 reset");
      rst_n = 1'b1;
      // R1 R4 default window, ceiling clamp
      run("R1", 148500, 0, 2, 64'h31333000, 500000, 1'b0);
      // R3 doubled window
      run("R3", 148500, 0, 2, 64'h31333100, 1000000, 1'b0);
      // R1 in-range RGB565
      run("R1", 27000, 3, 2, 64'h31333000, 260000, 1'b0);
      // R2 floor clamp, packed RGB666, ui wraps to 6 bits
      run("R2", 1000, 2, 4, 64'h31333000, 31250, 1'b0);
      // R3 doubled floor
      run("R3", 1000, 0, 1, 64'h313331AB, 62500, 1'b0);
      // R7 unknown format falls back
      run("R7", 20000, 6, 3, 64'h0, 123456, 1'b0);
      // R10 zero lanes
      run("R10", 15000, 1, 0, 64'h0, 216000, 1'b0);
      // R5 zero PLL rate
      run("R5", 30000, 1, 4, 64'h0, 0, 1'b0);
      // R9 second start while busy ignored
      run("R9", 50000, 0, 4, 64'h31333000, 360000, 1'b1);
      // R8 rounding down of Mbps
      run("R8", 40000, 3, 1, 64'h31333100, 999999, 1'b0);
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule